// File: doc/BRIEF.md
# HDLC Frame Transmitter with Threshold FIFO

The block accepts packet octets from a host write port into a transmit FIFO and sends them as HDLC frames, one bit per line strobe. Octets go out least significant bit first. Each frame is framed by 0x7E flags, zero-bit stuffing keeps the payload free of flag patterns, and a 16-bit frame check sequence is appended when enabled. When no frame is ready, the line carries back-to-back flags. The host tags the final octet of a packet with an end-of-message bit as it writes it.

A frame begins only at a flag boundary. Two things must hold: the transmitter is enabled, and the FIFO holds either a complete packet or at least the programmed upper fill threshold. If the FIFO runs dry before the end-of-message octet has left, the frame is aborted with seven ones. Four sticky event flags record these conditions:

- low fill reached during a frame
- underrun
- a write dropped on a full FIFO (overrun)
- the FIFO becoming full

Each flag has its own interrupt enable, and the host clears the flags by writing ones.

Top module: `hdlc_tx`

## Requirements
- R1: After reset, fifo_level is 0, irq_flags is 0, irq is 0 and tx_bit is 1.
- R2: While no frame is being sent, the line carries repeated 0x7E flags, each sent least significant bit first.
- R3: A frame is an opening flag, then the packet octets in write order, each sent least significant bit first, then a closing flag. Inside the octets and FCS, a 0 is inserted after every five consecutive 1 bits.
- R4: With cfg_crc_on high, two FCS octets follow the data, low octet first. The FCS is the complement of a CRC-16 with polynomial x^16+x^12+x^5+1, bit-reflected, initial value 0xFFFF. A receiver computing the same CRC over data plus FCS obtains 0xF0B8. With cfg_crc_on low, no FCS is sent.
- R5: A frame starts at the end of a flag only if cfg_en is high and the FIFO holds either an octet with the end-of-message tag or at least cfg_upper octets. Otherwise the FIFO is not read.
- R6: tx_bit changes only on a clock edge where bit_strobe is high, and exactly one line bit is emitted per strobe.
- R7: If the FIFO is empty when the next octet of an unfinished packet is needed, seven 1 bits are sent, flags resume, and irq_flags[1] (underrun) is set.
- R8: A write while fifo_level equals DEPTH is dropped, leaves fifo_level unchanged, and sets irq_flags[2] (overrun).
- R9: irq_flags[3] (full) is set when fifo_level reaches DEPTH.
- R10: irq_flags[0] (low fill) is set when the serializer reads an octet while fifo_level equals a nonzero cfg_lower. A cfg_lower of 0 never sets it.
- R11: irq is the OR over i of irq_flags[i] AND irq_en[i]. Flags stay set until a 1 is written to the same bit of irq_clr, and a new event in that cycle wins.
- R12: A cycle with cfg_fifo_clr high empties the FIFO and forgets any pending end-of-message, so a later partial packet does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Allows new frames to start |
| cfg_fifo_clr | input | 1 | Empties the FIFO while high |
| cfg_crc_on | input | 1 | Appends the FCS |
| cfg_upper | input | LW | Fill level that starts a frame without end-of-message |
| cfg_lower | input | LW | Low-fill level watched during a frame (0 disables) |
| irq_en | input | 4 | Per-flag interrupt enables |
| irq_clr | input | 4 | Write-one-to-clear for irq_flags |
| wr_valid | input | 1 | Host octet write |
| wr_data | input | 8 | Octet to queue |
| wr_eom | input | 1 | Marks the octet as last of its packet |
| bit_strobe | input | 1 | Emit one line bit this cycle |
| tx_bit | output | 1 | Serial line bit |
| fifo_level | output | LW | Octets held in the FIFO |
| irq_flags | output | 4 | Sticky events: [3] full, [2] overrun, [1] underrun, [0] low fill |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest state to reach is an underrun. It needs a frame already under way on a threshold start, with no end-of-message written, and the FIFO draining faster than the host refills it. The bench gets there by lowering cfg_upper to two, writing exactly two untagged octets and then letting the strobe run unhindered. A bench-side HDLC receiver then decodes the captured line bits: it removes stuffing, finds flags and aborts, and checks every frame against the queued packets and the CRC residue. As a result, stuffing, FCS order and abort shape are checked by decoding rather than by mirroring the serializer.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    SR_IDLE,
    SR_DATA,
    SR_FCS_LO,
    SR_FCS_HI,
    SR_ABORT
  } ser_state_e;

  localparam logic [7:0]  FLAG_OCTET = 8'h7E;
  localparam logic [7:0]  ABORT_RUN  = 8'h7F;
  localparam logic [15:0] FCS_SEED   = 16'hFFFF;
  localparam logic [15:0] FCS_POLY_R = 16'h8408;

  // one octet through the reflected CRC-16, LSB first
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ FCS_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       crc_on,
  input  logic       strobe,
  input  logic       start_ok,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_dout,
  input  logic       fifo_eom,
  output logic       pop,
  output logic       underrun_ev,
  output logic       frame_active,
  output logic       tx_bit
);

  ser_state_e  state, nx_state;
  logic [7:0]  sh, nx_sh;
  logic [3:0]  cnt, nx_cnt;
  logic        stuf, nx_stuf;
  logic [2:0]  ones;
  logic [15:0] crc, nx_crc;
  logic        last_eom, nx_eom;
  logic        take, udr;
  logic        stuff_now, boundary;

  assign stuff_now    = (ones == 3'd5);
  assign boundary     = strobe && !stuff_now && (cnt == 4'd1);
  assign pop          = boundary && take;
  assign underrun_ev  = boundary && udr;
  assign frame_active = (state != SR_IDLE);

  // choice of the next unit on the line, taken at each unit boundary
  always_comb begin
    nx_state = state;
    nx_sh    = FLAG_OCTET;
    nx_cnt   = 4'd8;
    nx_stuf  = 1'b0;
    nx_crc   = crc;
    nx_eom   = last_eom;
    take     = 1'b0;
    udr      = 1'b0;
    case (state)
      SR_IDLE: begin
        if (en && start_ok && !fifo_empty) begin
          take     = 1'b1;
          nx_sh    = fifo_dout;
          nx_stuf  = 1'b1;
          nx_crc   = fcs_step(FCS_SEED, fifo_dout);
          nx_eom   = fifo_eom;
          nx_state = SR_DATA;
        end
      end
      SR_DATA: begin
        if (last_eom) begin
          if (crc_on) begin
            nx_sh    = ~crc[7:0];
            nx_stuf  = 1'b1;
            nx_state = SR_FCS_LO;
          end else begin
            nx_state = SR_IDLE;
          end
        end else if (fifo_empty) begin
          nx_sh    = ABORT_RUN;
          nx_cnt   = 4'd7;
          udr      = 1'b1;
          nx_state = SR_ABORT;
        end else begin
          take    = 1'b1;
          nx_sh   = fifo_dout;
          nx_stuf = 1'b1;
          nx_crc  = fcs_step(crc, fifo_dout);
          nx_eom  = fifo_eom;
        end
      end
      SR_FCS_LO: begin
        nx_sh    = ~crc[15:8];
        nx_stuf  = 1'b1;
        nx_state = SR_FCS_HI;
      end
      default: nx_state = SR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SR_IDLE;
      sh       <= FLAG_OCTET;
      cnt      <= 4'd8;
      stuf     <= 1'b0;
      ones     <= '0;
      crc      <= FCS_SEED;
      last_eom <= 1'b0;
      tx_bit   <= 1'b1;
    end else if (strobe) begin
      if (stuff_now) begin
        tx_bit <= 1'b0;
        ones   <= '0;
      end else begin
        tx_bit <= sh[0];
        ones   <= (stuf && sh[0]) ? ones + 3'd1 : 3'd0;
        if (cnt == 4'd1) begin
          state    <= nx_state;
          sh       <= nx_sh;
          cnt      <= nx_cnt;
          stuf     <= nx_stuf;
          crc      <= nx_crc;
          last_eom <= nx_eom;
        end else begin
          sh  <= sh >> 1;
          cnt <= cnt - 4'd1;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_tx_irq.sv
module hdlc_tx_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flags[i] <= 1'b0;
      else if (ev[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & en);

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_fifo_clr,
  input  logic          cfg_crc_on,
  input  logic [LW-1:0] cfg_upper,
  input  logic [LW-1:0] cfg_lower,
  input  logic [3:0]    irq_en,
  input  logic [3:0]    irq_clr,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  input  logic          wr_eom,
  input  logic          bit_strobe,
  output logic          tx_bit,
  output logic [LW-1:0] fifo_level,
  output logic [3:0]    irq_flags,
  output logic          irq
);

  logic [8:0]    q_dout;
  logic          q_full, q_empty, q_pop;
  logic          wr_take, full_q;
  logic [LW-1:0] eom_cnt;
  logic          start_ok, frame_active;
  logic          ev_full, ev_ovr, ev_udr, ev_low;

  function automatic logic low_cross(input logic popping,
                                     input logic [LW-1:0] lvl,
                                     input logic [LW-1:0] thr);
    return popping && (thr != '0) && (lvl == thr);
  endfunction

  assign wr_take  = wr_valid && !q_full && !cfg_fifo_clr;
  assign start_ok = (eom_cnt != '0) || (fifo_level >= cfg_upper);

  hdlc_tx_fifo #(.DEPTH(DEPTH), .W(9)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_fifo_clr),
    .push  (wr_take),
    .din   ({wr_eom, wr_data}),
    .pop   (q_pop),
    .dout  (q_dout),
    .level (fifo_level),
    .full  (q_full),
    .empty (q_empty)
  );

  hdlc_tx_ser u_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (cfg_en),
    .crc_on       (cfg_crc_on),
    .strobe       (bit_strobe),
    .start_ok     (start_ok),
    .fifo_empty   (q_empty),
    .fifo_dout    (q_dout[7:0]),
    .fifo_eom     (q_dout[8]),
    .pop          (q_pop),
    .underrun_ev  (ev_udr),
    .frame_active (frame_active),
    .tx_bit       (tx_bit)
  );

  // count of complete packets held in the FIFO
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eom_cnt <= '0;
      full_q  <= 1'b0;
    end else begin
      full_q <= q_full;
      if (cfg_fifo_clr) eom_cnt <= '0;
      else begin
        case ({wr_take && wr_eom, q_pop && q_dout[8]})
          2'b10:   eom_cnt <= eom_cnt + LW'(1);
          2'b01:   eom_cnt <= eom_cnt - LW'(1);
          default: eom_cnt <= eom_cnt;
        endcase
      end
    end
  end

  assign ev_full = q_full && !full_q;
  assign ev_ovr  = wr_valid && q_full && !cfg_fifo_clr;
  assign ev_low  = low_cross(q_pop, fifo_level, cfg_lower);

  hdlc_tx_irq #(.N(4)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    ({ev_full, ev_ovr, ev_udr, ev_low}),
    .en    (irq_en),
    .clr   (irq_clr),
    .flags (irq_flags),
    .irq   (irq)
  );

endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_fifo_clr,
  input logic          wr_valid,
  input logic          bit_strobe,
  input logic          tx_bit,
  input logic [LW-1:0] fifo_level,
  input logic [3:0]    irq_flags,
  input logic [3:0]    irq_en,
  input logic          irq,
  input logic          frame_active
);

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  // R8
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && fifo_level == LW'(DEPTH) && !cfg_fifo_clr) |=> irq_flags[2]);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |=> $stable(tx_bit));

  // R6
  pop_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_strobe && !cfg_fifo_clr) |=> fifo_level >= $past(fifo_level));

  // R5
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_active) |-> $past(cfg_en));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'b0000) |-> !irq);

endmodule

bind hdlc_tx hdlc_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_en       (cfg_en),
  .cfg_fifo_clr (cfg_fifo_clr),
  .wr_valid     (wr_valid),
  .bit_strobe   (bit_strobe),
  .tx_bit       (tx_bit),
  .fifo_level   (fifo_level),
  .irq_flags    (irq_flags),
  .irq_en       (irq_en),
  .irq          (irq),
  .frame_active (frame_active)
);

// File: tb/hdlc_tx_bench.sv
`timescale 1ns/1ps
module hdlc_tx_bench;

  localparam int DEPTH = 32;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b0, cfg_fifo_clr = 1'b0, cfg_crc_on = 1'b0;
  logic [LW-1:0] cfg_upper = LW'(DEPTH), cfg_lower = '0;
  logic [3:0]    irq_en = '0, irq_clr = '0;
  logic          wr_valid = 1'b0, wr_eom = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          bit_strobe = 1'b0;
  logic          tx_bit;
  logic [LW-1:0] fifo_level;
  logic [3:0]    irq_flags;
  logic          irq;

  always #2.5 clk = ~clk;

  hdlc_tx #(.DEPTH(DEPTH)) u_hdlc_tx (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_fifo_clr(cfg_fifo_clr),
    .cfg_crc_on(cfg_crc_on), .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
    .irq_en(irq_en), .irq_clr(irq_clr), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_eom(wr_eom), .bit_strobe(bit_strobe), .tx_bit(tx_bit),
    .fifo_level(fifo_level), .irq_flags(irq_flags), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe generator
  bit strobe_on = 0;
  int strobe_gap = 1;
  initial forever begin
    @(negedge clk);
    bit_strobe <= strobe_on && (($urandom % strobe_gap) == 0);
  end

  // bench-side HDLC receiver
  logic      fire_q = 1'b0;
  int        ones = 0, rx_flags = 0, rx_frames = 0, rx_aborts = 0;
  bit        in_frame = 0;
  bit        rxq[$];
  int        exp_len[$];
  bit        exp_crc[$];
  logic [7:0] exp_bytes[$];

  always @(posedge clk) fire_q <= bit_strobe && rst_n;

  task automatic finish_frame();
    int n, nb, L;
    bit c, ok;
    logic [7:0] fb[$];
    logic [15:0] r;
    n  = rxq.size() - 7;
    nb = n / 8;
    ok = (n % 8 == 0);
    for (int k = 0; k < nb; k++) begin
      logic [7:0] v;
      v = '0;
      for (int j = 0; j < 8; j++) v[j] = rxq[k*8 + j];
      fb.push_back(v);
    end
    rx_frames++;
    if (exp_len.size() == 0) begin
      chk(0, "R3 unexpected frame", nb, 0);
      return;
    end
    L = exp_len.pop_front();
    c = exp_crc.pop_front();
    if (nb != L + (c ? 2 : 0)) ok = 0;
    for (int k = 0; k < L; k++) begin
      logic [7:0] e;
      e = exp_bytes.pop_front();
      if (k >= nb || fb[k] != e) ok = 0;
    end
    chk(ok, "R3 frame octets", nb, L + (c ? 2 : 0));
    if (c) begin
      r = 16'hFFFF;
      for (int k = 0; k < nb; k++)
        for (int j = 0; j < 8; j++) begin
          bit fbk;
          fbk = r[0] ^ fb[k][j];
          r = r >> 1;
          if (fbk) r = r ^ 16'h8408;
        end
      chk(r == 16'hF0B8, "R4 FCS residue", r, 16'hF0B8);
    end
  endtask

  always @(negedge clk) begin
    if (fire_q) begin
      if (tx_bit) begin
        ones++;
        if (ones == 7) begin
          rx_aborts++;
          in_frame = 0;
          rxq.delete();
        end else if (in_frame && ones < 7) rxq.push_back(1'b1);
      end else begin
        if (ones == 6) begin
          rx_flags++;
          if (in_frame && rxq.size() > 7) finish_frame();
          rxq.delete();
          in_frame = 1;
        end else if (ones != 5 && in_frame) rxq.push_back(1'b0);
        ones = 0;
      end
    end
  end

  task automatic push(input logic [7:0] d, input bit e);
    while (fifo_level == LW'(DEPTH)) @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_eom = e;
    @(negedge clk);
    wr_valid = 1'b0; wr_eom = 1'b0;
  endtask

  // mode 0 random, 1 all ones, 2 all flag patterns
  task automatic queue_pkt(input int len, input bit c, input int mode, output logic [7:0] pk[$]);
    pk.delete();
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = (mode == 1) ? 8'hFF : (mode == 2) ? 8'h7E : 8'($urandom);
      pk.push_back(b);
      exp_bytes.push_back(b);
    end
    exp_len.push_back(len);
    exp_crc.push_back(c);
  endtask

  task automatic send_pkt(input int len, input bit c, input int mode);
    logic [7:0] pk[$];
    int target;
    target = rx_frames + 1;
    cfg_crc_on = c;
    queue_pkt(len, c, mode, pk);
    for (int i = 0; i < len; i++) push(pk[i], i == len - 1);
    while (rx_frames < target) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    irq_clr = 4'hF; @(negedge clk); irq_clr = 4'h0; @(negedge clk);
  endtask

  initial begin
    logic [7:0] pk[$];
    logic saved;
    int f0, a0;
    void'($urandom(32'h1D5EED));
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fifo_level == 0, "R1 level", fifo_level, 0);
    chk(irq_flags == 0, "R1 flags", irq_flags, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(tx_bit == 1, "R1 tx_bit", tx_bit, 1);

    cfg_en = 1'b1; cfg_crc_on = 1'b1;
    strobe_on = 1; strobe_gap = 1;
    idle(200);
    // R2 idle flags only
    chk(rx_flags >= 10, "R2 idle flags", rx_flags, 10);
    chk(rx_frames == 0, "R2 no frame", rx_frames, 0);

    // R6 line holds without strobes
    strobe_on = 0; idle(4);
    saved = tx_bit;
    idle(60);
    chk(tx_bit == saved, "R6 hold", tx_bit, saved);
    strobe_on = 1;

    // R3 stuffing corner cases
    send_pkt(6, 1, 1);
    send_pkt(5, 0, 2);
    send_pkt(1, 1, 0);

    // R3 R4 random packets
    for (int p = 0; p < 20; p++) begin
      strobe_gap = 1 + ($urandom % 3);
      send_pkt(1 + ($urandom % 24), 1'($urandom), 0);
    end
    strobe_gap = 1;

    // R5 disabled: complete packet stays queued
    cfg_en = 1'b0; cfg_crc_on = 1'b1;
    f0 = rx_frames;
    queue_pkt(4, 1, 0, pk);
    for (int i = 0; i < 4; i++) push(pk[i], i == 3);
    idle(300);
    chk(fifo_level == 4, "R5 disabled level", fifo_level, 4);
    chk(rx_frames == f0, "R5 disabled frames", rx_frames, f0);
    cfg_en = 1'b1;
    while (rx_frames < f0 + 1) @(negedge clk);

    // R5 upper threshold start
    cfg_upper = LW'(4); strobe_gap = 8;
    f0 = rx_frames;
    queue_pkt(8, 1, 0, pk);
    for (int i = 0; i < 3; i++) push(pk[i], 0);
    idle(400);
    chk(fifo_level == 3, "R5 below upper", fifo_level, 3);
    for (int i = 3; i < 8; i++) push(pk[i], i == 7);
    while (rx_frames < f0 + 1) @(negedge clk);
    chk(fifo_level == 0, "R5 threshold frame drained", fifo_level, 0);
    strobe_gap = 1;

    // R7 underrun
    clear_flags();
    cfg_upper = LW'(2);
    f0 = rx_frames; a0 = rx_aborts;
    push(8'hA5, 0); push(8'h3C, 0);
    idle(300);
    chk(irq_flags[1] == 1, "R7 underrun flag", irq_flags[1], 1);
    chk(rx_aborts > a0, "R7 abort seen", rx_aborts, a0 + 1);
    chk(rx_frames == f0, "R7 no frame", rx_frames, f0);
    irq_en = 4'b0010; @(negedge clk);
    chk(irq == 1, "R11 irq underrun", irq, 1);
    irq_clr = 4'b0010; @(negedge clk); irq_clr = 4'b0000; @(negedge clk);
    chk(irq_flags == 0 && irq == 0, "R11 clear", irq_flags, 0);
    irq_en = 4'b0000;
    cfg_upper = LW'(DEPTH);

    // R10 low fill
    cfg_lower = LW'(4);
    send_pkt(10, 1, 0);
    chk(irq_flags[0] == 1, "R10 low fill", irq_flags[0], 1);
    clear_flags();
    send_pkt(3, 1, 0);
    chk(irq_flags[0] == 0, "R10 short packet", irq_flags[0], 0);
    cfg_lower = '0;
    send_pkt(12, 0, 0);
    chk(irq_flags[0] == 0, "R10 disabled", irq_flags[0], 0);

    // R8 R9 overrun and full
    clear_flags();
    cfg_en = 1'b0; strobe_on = 0; idle(4);
    for (int i = 0; i < DEPTH; i++) push(8'(i), 0);
    @(negedge clk);
    chk(fifo_level == LW'(DEPTH), "R9 level full", fifo_level, DEPTH);
    chk(irq_flags[3] == 1, "R9 full flag", irq_flags[3], 1);
    chk(irq_flags[2] == 0, "R8 no overrun yet", irq_flags[2], 0);
    wr_valid = 1'b1; wr_data = 8'hEE; @(negedge clk); wr_valid = 1'b0; @(negedge clk);
    chk(fifo_level == LW'(DEPTH), "R8 level kept", fifo_level, DEPTH);
    chk(irq_flags[2] == 1, "R8 overrun flag", irq_flags[2], 1);
    chk(irq == 0, "R11 masked", irq, 0);
    irq_en = 4'b1000; @(negedge clk);
    chk(irq == 1, "R11 full enabled", irq, 1);
    irq_en = 4'b0000;

    // R12 clear
    cfg_fifo_clr = 1'b1; @(negedge clk); cfg_fifo_clr = 1'b0; @(negedge clk);
    chk(fifo_level == 0, "R12 cleared", fifo_level, 0);
    push(8'h11, 0); push(8'h22, 1);
    cfg_fifo_clr = 1'b1; @(negedge clk); cfg_fifo_clr = 1'b0; @(negedge clk);
    push(8'h33, 0);
    f0 = rx_frames;
    cfg_en = 1'b1; strobe_on = 1;
    idle(300);
    chk(fifo_level == 1, "R12 eom forgotten", fifo_level, 1);
    chk(rx_frames == f0, "R12 no frame", rx_frames, f0);
    cfg_fifo_clr = 1'b1; @(negedge clk); cfg_fifo_clr = 1'b0; @(negedge clk);

    chk(exp_len.size() == 0, "R3 all frames received", exp_len.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule